// File: doc/BRIEF.md
# Bidirectional Port Controller with Mailbox Exchange

This block is the control side of one port of a two-port FIFO system in which a single 36-bit data bus carries traffic in both directions. On every rising edge of the port clock it decodes four control inputs (an active-low chip select, a direction select, an enable and a mailbox select) into one action: write the bus word into the outbound FIFO, read a word from the inbound FIFO, write the outbound mailbox, or read the inbound mailbox. It also produces the output enable for the bus drivers and the multiplexer that chooses what the bus carries when the port reads. The FIFO arrays themselves live outside the block; the block only issues write and read strobes to them, gated by their space and data flags.

Two single-word mailboxes bypass the FIFOs. The outbound mailbox is written from this port and read from the partner port; the inbound one is written by the partner and read here. Each mailbox has an active-low "mail held" flag on each side, driven by a small handshake state machine in each clock domain. A toggle bit crosses between the domains through a two-flop synchronizer, so the partner clock may be fully unrelated to the local one. A parameter chooses which level of the direction select means "write", so the same block serves either side of the pair.

Writer-side state machine states: TX_FREE (mailbox may be written) and TX_HELD (word written, waiting for the partner's read to return). Transitions: FREE to HELD on an accepted mailbox write; HELD to FREE when the synchronized read toggle matches the write toggle. Reader-side states: RX_WAIT (no unread mail) and RX_MAIL (unread word present). Transitions: WAIT to MAIL when the synchronized write toggle differs from the read toggle; MAIL to WAIT on an accepted mailbox read.

Top module: `biport_ctrl`

## Requirements
- R1: While `cs_n` is 1, `bus_oe` is 0, `fifo_wr` and `fifo_rd` are 0, and no mailbox write or read is taken, whatever the other control inputs are.
- R2: While `cs_n` is 0, `bus_oe` is 1 exactly when the read direction is selected, independent of `en` and `mbx_sel`.
- R3: While `en` is 0, no FIFO strobe is raised and no mailbox write or read is taken, even though `bus_oe` still follows R2.
- R4: `fifo_wr` is 1 exactly when `cs_n`=0, write direction, `en`=1, `mbx_sel`=0 and `fifo_full_n`=1.
- R5: `fifo_rd` is 1 exactly when `cs_n`=0, read direction, `en`=1, `mbx_sel`=0 and `fifo_empty_n`=1.
- R6: A mailbox write (`cs_n`=0, write direction, `en`=1, `mbx_sel`=1) while `outbox_empty`=1 captures `din` and drives `outbox_empty` to 0 after that edge; a mailbox write while `outbox_empty`=0 is ignored and the held word is unchanged.
- R7: After a local mailbox write at clock edge k, the partner's `r_inbox_empty` stays 1 through partner edge k+2 and is 0 after edge k+3 (two synchronizer flops plus the state register, clocks aligned), with `r_mbx_q` showing the written word.
- R8: A mailbox read while the reader's empty flag is 0 drives that flag to 1 after the edge; a mailbox read while the flag is already 1 has no effect.
- R9: After the partner reads the mailbox at edge j, the writer's empty flag stays 0 through edge j+2 and returns to 1 after edge j+3.
- R10: `dout` carries the inbound mailbox word when the read direction is selected and `mbx_sel`=1, and `fifo_q` in all other cases.
- R11: The write direction is `dir_sel`=1 when parameter `WR_SEL_HIGH` is 1 and `dir_sel`=0 when it is 0; the other level is the read direction.
- R12: After reset both empty flags on both sides are 1 and both mailbox words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local port clock |
| rst_n | input | 1 | Local asynchronous reset, active low |
| cs_n | input | 1 | Port select, active low |
| dir_sel | input | 1 | Direction select; write level set by WR_SEL_HIGH |
| en | input | 1 | Operation enable |
| mbx_sel | input | 1 | 1 routes the operation to the mailbox |
| din | input | 36 | Word arriving on the bus |
| dout | output | 36 | Word to drive on the bus |
| bus_oe | output | 1 | Bus driver enable |
| fifo_full_n | input | 1 | Outbound FIFO has space |
| fifo_empty_n | input | 1 | Inbound FIFO output register holds data |
| fifo_q | input | 36 | Inbound FIFO output register |
| fifo_wr | output | 1 | Outbound FIFO write strobe |
| fifo_rd | output | 1 | Inbound FIFO read strobe |
| outbox_empty | output | 1 | Outbound mailbox free (0 = unread mail held) |
| inbox_empty | output | 1 | Inbound mailbox has no unread mail (0 = mail) |
| rclk | input | 1 | Partner port clock |
| rrst_n | input | 1 | Partner-domain reset, active low |
| r_mbx_wr | input | 1 | Partner mailbox write request |
| r_mbx_rd | input | 1 | Partner mailbox read request |
| r_din | input | 36 | Partner word for the inbound mailbox |
| r_mbx_q | output | 36 | Outbound mailbox word as seen by the partner |
| r_outbox_empty | output | 1 | Partner view: inbound mailbox free to write |
| r_inbox_empty | output | 1 | Partner view: no unread word in outbound mailbox |

## Verification
The assertions assume the partner request lines and all control inputs are settled between clock edges and that each reset is held for at least one edge of its own clock; the bench drives every input a short time after a rising edge and samples well before the next one. The handshake assertions further assume the writer's word stays put while held, which holds by design, and the partner clock is tied to the local clock in the bench so that the synchronizer latency in R7 and R9 is an exact edge count. The decode sweep runs while reset holds both mailboxes empty, so every expected output follows from the inputs alone.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,
        ACT_FIFO_WR = 3'd1,
        ACT_FIFO_RD = 3'd2,
        ACT_MBX_WR  = 3'd3,
        ACT_MBX_RD  = 3'd4
    } port_act_e;

    typedef enum logic {
        TX_FREE = 1'b0,
        TX_HELD = 1'b1
    } tx_state_e;

    typedef enum logic {
        RX_WAIT = 1'b0,
        RX_MAIL = 1'b1
    } rx_state_e;

endpackage

// File: rtl/bpc_sync2.sv
module bpc_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bpc_decoder.sv
module bpc_decoder
    import bpc_pkg::*;
#(
    parameter bit WR_SEL_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic dir_sel,
    input  logic en,
    input  logic mbx_sel,
    input  logic fifo_full_n,
    input  logic fifo_empty_n,
    input  logic mb_space,
    input  logic mb_mail,
    output logic rd_dir,
    output logic bus_oe,
    output logic fifo_wr,
    output logic fifo_rd,
    output logic mb_wr,
    output logic mb_rd
);
    logic      wr_dir;
    port_act_e act;

    assign wr_dir = (dir_sel == WR_SEL_HIGH);
    assign rd_dir = !wr_dir;
    assign bus_oe = !cs_n && rd_dir;

    // decode of intent, before flag gating
    always_comb begin
        act = ACT_NONE;
        if (!cs_n && en) begin
            unique case ({wr_dir, mbx_sel})
                2'b10:   act = ACT_FIFO_WR;
                2'b11:   act = ACT_MBX_WR;
                2'b00:   act = ACT_FIFO_RD;
                default: act = ACT_MBX_RD;
            endcase
        end
    end

    // strobes, gated by the target's flag
    always_comb begin
        fifo_wr = 1'b0;
        fifo_rd = 1'b0;
        mb_wr   = 1'b0;
        mb_rd   = 1'b0;
        unique case (act)
            ACT_FIFO_WR: fifo_wr = fifo_full_n;
            ACT_FIFO_RD: fifo_rd = fifo_empty_n;
            ACT_MBX_WR:  mb_wr   = mb_space;
            ACT_MBX_RD:  mb_rd   = mb_mail;
            default:     ;
        endcase
    end

    // R1
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !(fifo_wr || fifo_rd || mb_wr || mb_rd || bus_oe));

    // R3
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !(fifo_wr || fifo_rd || mb_wr || mb_rd));

    // R4
    single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_wr, fifo_rd, mb_wr, mb_rd}));

    // R2
    oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !(fifo_wr || mb_wr));
endmodule

// File: rtl/bpc_mailbox.sv
module bpc_mailbox
    import bpc_pkg::*;
#(
    parameter int W = 36
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wdata,
    output logic         w_empty,
    input  logic         rclk,
    input  logic         rrst_n,
    input  logic         rd_req,
    output logic [W-1:0] rdata,
    output logic         r_empty
);
    // writer domain
    tx_state_e    tx_state, tx_next;
    logic         wtog;
    logic         rtog_at_w;
    logic [W-1:0] word;

    // reader domain
    rx_state_e    rx_state, rx_next;
    logic         rtog;
    logic         wtog_at_r;

    bpc_sync2 #(.STAGES(2)) u_sync_rtog (
        .clk(wclk), .rst_n(wrst_n), .d(rtog), .q(rtog_at_w)
    );

    bpc_sync2 #(.STAGES(2)) u_sync_wtog (
        .clk(rclk), .rst_n(rrst_n), .d(wtog), .q(wtog_at_r)
    );

    // writer next state
    always_comb begin
        tx_next = tx_state;
        unique case (tx_state)
            TX_FREE: if (wr_req)            tx_next = TX_HELD;
            TX_HELD: if (rtog_at_w == wtog) tx_next = TX_FREE;
            default:                        tx_next = TX_FREE;
        endcase
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) tx_state <= TX_FREE;
        else         tx_state <= tx_next;
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wtog <= 1'b0;
            word <= '0;
        end else if (tx_state == TX_FREE && wr_req) begin
            wtog <= !wtog;
            word <= wdata;
        end
    end

    assign w_empty = (tx_state == TX_FREE);

    // reader next state
    always_comb begin
        rx_next = rx_state;
        unique case (rx_state)
            RX_WAIT: if (wtog_at_r != rtog) rx_next = RX_MAIL;
            RX_MAIL: if (rd_req)            rx_next = RX_WAIT;
            default:                        rx_next = RX_WAIT;
        endcase
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) rx_state <= RX_WAIT;
        else         rx_state <= rx_next;
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n)                              rtog <= 1'b0;
        else if (rx_state == RX_MAIL && rd_req)   rtog <= !rtog;
    end

    // word is held stable by the writer until the read toggle returns
    assign rdata   = word;
    assign r_empty = (rx_state == RX_WAIT);

    // R6
    mbx_capture_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        (w_empty && wr_req) |=> (!w_empty && rdata == $past(wdata)));

    // R6
    mbx_hold_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        (!w_empty && !$past(w_empty)) |-> $stable(rdata));

    // R8
    mbx_read_clear_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        (!r_empty && rd_req) |=> r_empty);
endmodule

// File: rtl/biport_ctrl.sv
module biport_ctrl #(
    parameter int W           = 36,
    parameter bit WR_SEL_HIGH = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         dir_sel,
    input  logic         en,
    input  logic         mbx_sel,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         bus_oe,
    input  logic         fifo_full_n,
    input  logic         fifo_empty_n,
    input  logic [W-1:0] fifo_q,
    output logic         fifo_wr,
    output logic         fifo_rd,
    output logic         outbox_empty,
    output logic         inbox_empty,
    input  logic         rclk,
    input  logic         rrst_n,
    input  logic         r_mbx_wr,
    input  logic         r_mbx_rd,
    input  logic [W-1:0] r_din,
    output logic [W-1:0] r_mbx_q,
    output logic         r_outbox_empty,
    output logic         r_inbox_empty
);
    logic         rd_dir;
    logic         mb_wr;
    logic         mb_rd;
    logic [W-1:0] inbox_q;

    bpc_decoder #(.WR_SEL_HIGH(WR_SEL_HIGH)) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .dir_sel      (dir_sel),
        .en           (en),
        .mbx_sel      (mbx_sel),
        .fifo_full_n  (fifo_full_n),
        .fifo_empty_n (fifo_empty_n),
        .mb_space     (outbox_empty),
        .mb_mail      (!inbox_empty),
        .rd_dir       (rd_dir),
        .bus_oe       (bus_oe),
        .fifo_wr      (fifo_wr),
        .fifo_rd      (fifo_rd),
        .mb_wr        (mb_wr),
        .mb_rd        (mb_rd)
    );

    // this port writes, partner reads
    bpc_mailbox #(.W(W)) u_outbox (
        .wclk    (clk),
        .wrst_n  (rst_n),
        .wr_req  (mb_wr),
        .wdata   (din),
        .w_empty (outbox_empty),
        .rclk    (rclk),
        .rrst_n  (rrst_n),
        .rd_req  (r_mbx_rd),
        .rdata   (r_mbx_q),
        .r_empty (r_inbox_empty)
    );

    // partner writes, this port reads
    bpc_mailbox #(.W(W)) u_inbox (
        .wclk    (rclk),
        .wrst_n  (rrst_n),
        .wr_req  (r_mbx_wr),
        .wdata   (r_din),
        .w_empty (r_outbox_empty),
        .rclk    (clk),
        .rrst_n  (rst_n),
        .rd_req  (mb_rd),
        .rdata   (inbox_q),
        .r_empty (inbox_empty)
    );

    assign dout = (rd_dir && mbx_sel) ? inbox_q : fifo_q;

    // R10
    dout_mailbox_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && !mbx_sel) |-> (dout == fifo_q));
endmodule

// File: tb/tb_biport_ctrl.sv
module tb_biport_ctrl;
    localparam int W = 36;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1, dir_sel = 1'b0, en = 1'b0, mbx_sel = 1'b0;
    logic [W-1:0] din = '0, fifo_q = '0, r_din = '0;
    logic         fifo_full_n = 1'b0, fifo_empty_n = 1'b0;
    logic         r_mbx_wr = 1'b0, r_mbx_rd = 1'b0;

    logic [W-1:0] dout, r_mbx_q, dout_b, r_mbx_q_b;
    logic bus_oe, fifo_wr, fifo_rd, outbox_empty, inbox_empty, r_outbox_empty, r_inbox_empty;
    logic bus_oe_b, fifo_wr_b, fifo_rd_b, outbox_empty_b, inbox_empty_b, r_outbox_empty_b, r_inbox_empty_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = !clk;

    biport_ctrl #(.W(W), .WR_SEL_HIGH(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dir_sel(dir_sel), .en(en), .mbx_sel(mbx_sel),
        .din(din), .dout(dout), .bus_oe(bus_oe), .fifo_full_n(fifo_full_n),
        .fifo_empty_n(fifo_empty_n), .fifo_q(fifo_q), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd),
        .outbox_empty(outbox_empty), .inbox_empty(inbox_empty), .rclk(clk), .rrst_n(rst_n),
        .r_mbx_wr(r_mbx_wr), .r_mbx_rd(r_mbx_rd), .r_din(r_din), .r_mbx_q(r_mbx_q),
        .r_outbox_empty(r_outbox_empty), .r_inbox_empty(r_inbox_empty)
    );

    biport_ctrl #(.W(W), .WR_SEL_HIGH(1'b0)) dut_b (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dir_sel(dir_sel), .en(en), .mbx_sel(mbx_sel),
        .din(din), .dout(dout_b), .bus_oe(bus_oe_b), .fifo_full_n(fifo_full_n),
        .fifo_empty_n(fifo_empty_n), .fifo_q(fifo_q), .fifo_wr(fifo_wr_b), .fifo_rd(fifo_rd_b),
        .outbox_empty(outbox_empty_b), .inbox_empty(inbox_empty_b), .rclk(clk), .rrst_n(rst_n),
        .r_mbx_wr(1'b0), .r_mbx_rd(1'b0), .r_din('0), .r_mbx_q(r_mbx_q_b),
        .r_outbox_empty(r_outbox_empty_b), .r_inbox_empty(r_inbox_empty_b)
    );

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp,
                       input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one rising edge, then settle 2 ns past it
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_ctl();
        cs_n = 1'b1; en = 1'b0; mbx_sel = 1'b0;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] word_a, word_b, word_c;
        word_a = 36'hA_1234_5678;
        word_b = 36'h5_DEAD_BEEF;
        word_c = 36'h9_0F0F_3C3C;

        // reset state, R12
        step();
        chk(outbox_empty,   1'b1, "R12", "outbox_empty");
        chk(inbox_empty,    1'b1, "R12", "inbox_empty");
        chk(r_outbox_empty, 1'b1, "R12", "r_outbox_empty");
        chk(r_inbox_empty,  1'b1, "R12", "r_inbox_empty");
        chk(r_mbx_q,        '0,   "R12", "r_mbx_q");

        // exhaustive decode sweep under reset (both mailboxes held empty):
        // R1 R2 R3 R4 R5 R10 R11
        for (int v = 0; v < 64; v++) begin
            logic wa, wb, e_oe, e_wr, e_rd;
            {cs_n, dir_sel, en, mbx_sel, fifo_full_n, fifo_empty_n} = v[5:0];
            fifo_q = 36'h3_5A5A_0000 ^ W'(v * 37);
            #3;
            for (int p = 0; p < 2; p++) begin
                wa = (p == 0) ? dir_sel : !dir_sel;  // R11 write level
                e_oe = !cs_n && !wa;
                e_wr = !cs_n && wa && en && !mbx_sel && fifo_full_n;
                e_rd = !cs_n && !wa && en && !mbx_sel && fifo_empty_n;
                if (p == 0) begin
                    chk(bus_oe,  e_oe, "R2", "bus_oe");
                    chk(fifo_wr, e_wr, "R4", "fifo_wr");
                    chk(fifo_rd, e_rd, "R5", "fifo_rd");
                    chk(dout, (!wa && mbx_sel) ? '0 : fifo_q, "R10", "dout");
                end else begin
                    wb = wa;
                    chk(bus_oe_b,  !cs_n && !wb, "R11", "bus_oe polarity");
                    chk(fifo_wr_b, e_wr, "R11", "fifo_wr polarity");
                    chk(fifo_rd_b, e_rd, "R11", "fifo_rd polarity");
                    chk(dout_b, (!wb && mbx_sel) ? '0 : fifo_q, "R10", "dout polarity");
                end
            end
            #3;
        end

        idle_ctl();
        fifo_full_n = 1'b0; fifo_empty_n = 1'b0; fifo_q = '0;
        step();
        rst_n = 1'b1;
        step();

        // R1: deselected mailbox write intent is ignored
        cs_n = 1'b1; dir_sel = 1'b1; en = 1'b1; mbx_sel = 1'b1; din = word_b;
        step();
        chk(outbox_empty, 1'b1, "R1", "outbox_empty after deselected write");
        // R3: enable low ignored
        cs_n = 1'b0; en = 1'b0;
        step();
        chk(outbox_empty, 1'b1, "R3", "outbox_empty after disabled write");
        chk(bus_oe, 1'b0, "R3", "bus_oe write dir with en low");

        // R6: accepted mailbox write at edge k
        din = word_a; en = 1'b1;
        step();
        en = 1'b0;
        chk(outbox_empty,  1'b0, "R6", "outbox_empty after write");
        chk(r_inbox_empty, 1'b1, "R7", "r_inbox_empty at k");
        step();
        chk(r_inbox_empty, 1'b1, "R7", "r_inbox_empty at k+1");
        step();
        chk(r_inbox_empty, 1'b1, "R7", "r_inbox_empty at k+2");
        step();
        chk(r_inbox_empty, 1'b0, "R7", "r_inbox_empty at k+3");
        chk(r_mbx_q, word_a, "R7", "r_mbx_q");

        // R6: write while held is ignored
        din = word_b; en = 1'b1;
        step();
        en = 1'b0;
        chk(outbox_empty, 1'b0, "R6", "outbox_empty after blocked write");
        chk(r_mbx_q, word_a, "R6", "held word unchanged");

        // R8 / R9: partner read at edge j
        r_mbx_rd = 1'b1;
        step();
        r_mbx_rd = 1'b0;
        chk(r_inbox_empty, 1'b1, "R8", "r_inbox_empty after partner read");
        chk(outbox_empty,  1'b0, "R9", "outbox_empty at j");
        step();
        chk(outbox_empty,  1'b0, "R9", "outbox_empty at j+1");
        step();
        chk(outbox_empty,  1'b0, "R9", "outbox_empty at j+2");
        step();
        chk(outbox_empty,  1'b1, "R9", "outbox_empty at j+3");

        // inbound: partner writes word_c
        idle_ctl();
        r_din = word_c; r_mbx_wr = 1'b1;
        step();
        r_mbx_wr = 1'b0;
        chk(r_outbox_empty, 1'b0, "R6", "r_outbox_empty after partner write");
        step(); step();
        chk(inbox_empty, 1'b1, "R7", "inbox_empty at k+2");
        step();
        chk(inbox_empty, 1'b0, "R7", "inbox_empty at k+3");

        // R10 read-direction multiplexer
        fifo_q = 36'h7_7777_1111;
        cs_n = 1'b0; dir_sel = 1'b0; en = 1'b0; mbx_sel = 1'b1;
        #2;
        chk(bus_oe, 1'b1, "R2", "bus_oe read dir en low");
        chk(dout, word_c, "R10", "dout mailbox");
        mbx_sel = 1'b0;
        #2;
        chk(dout, fifo_q, "R10", "dout fifo");

        // R1 / R3: mail stays while deselected or disabled
        cs_n = 1'b1; en = 1'b1; mbx_sel = 1'b1;
        step();
        chk(inbox_empty, 1'b0, "R1", "inbox_empty after deselected read");
        cs_n = 1'b0; en = 1'b0;
        step();
        chk(inbox_empty, 1'b0, "R3", "inbox_empty after disabled read");

        // R8: local mailbox read, then a read on empty
        en = 1'b1;
        step();
        chk(inbox_empty, 1'b1, "R8", "inbox_empty after read");
        step();
        en = 1'b0;
        chk(inbox_empty, 1'b1, "R8", "inbox_empty after empty read");
        chk(r_outbox_empty, 1'b0, "R9", "r_outbox_empty at j+1");
        step();
        chk(r_outbox_empty, 1'b0, "R9", "r_outbox_empty at j+2");
        step();
        chk(r_outbox_empty, 1'b1, "R9", "r_outbox_empty at j+3");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule